// File: doc/BRIEF.md
# Audio Frame Sequencer

This block is the frame timer of an audio unit. It advances one count on every clock edge, where each edge is one audio tick. Its outputs pace the slower parts of the sound channels: a quarter-frame pulse clocks envelopes, and a half-frame pulse clocks sweep and length units. In one of its two modes it also raises a frame interrupt.

Software picks the mode and can mask the interrupt by writing a control byte. The write does not act at once. The block holds the byte and applies it a few ticks later. The exact delay depends on the level of a phase toggle input at the time of the write. Applying the byte also restarts the count from zero. A status read strobe returns the frame interrupt flag and then clears it.

Top module: `frame_seq`

## Requirements
- R1: After reset the count is zero and no control write is pending. The mode is 4-step with the interrupt allowed. Outputs `qtr`, `half`, `irq` and `stat_frame_irq` are low.
- R2: Tick n is the n-th edge since reset, or since the last applied control byte. In 4-step mode `qtr` is high at ticks 7457, 14913, 22372 and 29830.
- R3: In 4-step mode `half` is high at ticks 14913 and 29829. The count wraps to zero at 29830, so the pattern repeats every 29830 ticks.
- R4: In 5-step mode `qtr` is high at 7458, 14913, 22372 and 37282, with no pulse at 29830. `half` is high at 14913 and 37281. The count wraps at 37282.
- R5: In 4-step mode with the interrupt allowed, the flag is set at ticks 29828, 29829 and 29830. In 5-step mode, or while the interrupt is masked, it is never set.
- R6: `irq` rises two ticks after tick 29829, which is tick 29831. It falls in the same tick that the flag clears.
- R7: `stat_frame_irq` shows the flag. A tick with `stat_rd` high clears the flag and drops `irq` from the next tick on.
- R8: When a status read falls on a tick where the flag is being set, the set wins and the flag stays high.
- R9: Control bit 7 selects the mode (0 = 4-step, 1 = 5-step) and bit 6 masks the interrupt. The byte is applied on the fourth tick, counting the write tick, if `phase` was 0 at the write. It is applied on the third tick if `phase` was 1. Applying it restarts the count at zero. A new write while one is pending replaces it.
- R10: Applying a byte with bit 6 set clears the flag and drops `irq` in that tick.
- R11: Every `qtr` and `half` pulse is exactly one tick wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Audio tick clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| phase | input | 1 | Phase toggle level, sampled with a control write |
| ctl_we | input | 1 | Control write strobe |
| ctl_data | input | 8 | Control byte (bit 7 mode, bit 6 interrupt mask) |
| stat_rd | input | 1 | Status read strobe, clears the flag |
| qtr | output | 1 | Quarter-frame pulse |
| half | output | 1 | Half-frame pulse |
| irq | output | 1 | Frame interrupt line |
| stat_frame_irq | output | 1 | Frame interrupt flag, status bit |

## Verification
A status read can land in the same tick as a flag set, and the two act on the flag in opposite directions. The bench provokes this by pulsing `stat_rd` exactly at tick 29829 of a 4-step frame. It judges the result by requiring that no flag-clear event appears and that the flag still reads high one tick later. A second read, made outside the set window, must clear the flag. A third collision puts an applied masking byte against a flag that is already set, and the flag must drop in the apply tick.

// File: rtl/frame_seq.sv
module frame_seq #(
  parameter int CNT_W       = 16,
  parameter int P4_Q1       = 7457,
  parameter int P4_Q2       = 14913,
  parameter int P4_Q3       = 22372,
  parameter int P4_END      = 29830,
  parameter int P5_Q1       = 7458,
  parameter int P5_Q2       = 14913,
  parameter int P5_Q3       = 22372,
  parameter int P5_END      = 37282,
  parameter int WR_LAT_EVEN = 4,
  parameter int WR_LAT_ODD  = 3,
  parameter int IRQ_LAT     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       phase,
  input  logic       ctl_we,
  input  logic [7:0] ctl_data,
  input  logic       stat_rd,
  output logic       qtr,
  output logic       half,
  output logic       irq,
  output logic       stat_frame_irq
);
  localparam int DLY_W = $clog2(WR_LAT_EVEN + 1);
  localparam int TMR_W = $clog2(IRQ_LAT + 1);
  localparam logic [CNT_W-1:0] A1 = CNT_W'(P4_Q1);
  localparam logic [CNT_W-1:0] A2 = CNT_W'(P4_Q2);
  localparam logic [CNT_W-1:0] A3 = CNT_W'(P4_Q3);
  localparam logic [CNT_W-1:0] AE = CNT_W'(P4_END);
  localparam logic [CNT_W-1:0] AH = CNT_W'(P4_END - 1);
  localparam logic [CNT_W-1:0] AF = CNT_W'(P4_END - 2);
  localparam logic [CNT_W-1:0] B1 = CNT_W'(P5_Q1);
  localparam logic [CNT_W-1:0] B2 = CNT_W'(P5_Q2);
  localparam logic [CNT_W-1:0] B3 = CNT_W'(P5_Q3);
  localparam logic [CNT_W-1:0] BE = CNT_W'(P5_END);
  localparam logic [CNT_W-1:0] BH = CNT_W'(P5_END - 1);
  localparam logic [DLY_W-1:0] LD_EVEN = DLY_W'(WR_LAT_EVEN - 1);
  localparam logic [DLY_W-1:0] LD_ODD  = DLY_W'(WR_LAT_ODD - 1);

  logic [CNT_W-1:0] cnt;
  logic             mode, inh, flag, irq_q;
  logic [1:0]       pend;
  logic [DLY_W-1:0] dly;
  logic [TMR_W-1:0] tmr;

  wire              ctl_unused = &{1'b0, ctl_data[5:0]};
  wire [CNT_W-1:0]  nxt   = cnt + 1'b1;
  wire              four  = !mode;
  wire              q_hit = four ? (nxt == A1 || nxt == A2 || nxt == A3 || nxt == AE)
                                 : (nxt == B1 || nxt == B2 || nxt == B3 || nxt == BE);
  wire              h_hit = four ? (nxt == A2 || nxt == AH) : (nxt == B2 || nxt == BH);
  wire              wrap  = four ? (nxt == AE) : (nxt == BE);
  wire              f_hit = four && !inh && nxt >= AF && nxt <= AE;
  wire              t_go  = four && !inh && nxt == AH;
  wire              apply = !ctl_we && dly == DLY_W'(1);
  wire              t_exp = tmr == TMR_W'(1);

  logic flag_n;
  always_comb begin
    flag_n = flag;
    if (stat_rd)          flag_n = 1'b0;
    if (f_hit)            flag_n = 1'b1;
    if (apply && pend[0]) flag_n = 1'b0;
  end

  assign irq            = irq_q;
  assign stat_frame_irq = flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      mode  <= 1'b0;
      inh   <= 1'b0;
      flag  <= 1'b0;
      irq_q <= 1'b0;
      pend  <= 2'b00;
      dly   <= '0;
      tmr   <= '0;
      qtr   <= 1'b0;
      half  <= 1'b0;
    end else begin
      qtr   <= q_hit;
      half  <= h_hit;
      flag  <= flag_n;
      irq_q <= (irq_q | t_exp) & flag_n;
      cnt   <= (apply || wrap) ? '0 : nxt;

      if (t_go)              tmr <= TMR_W'(IRQ_LAT);
      else if (tmr != '0)    tmr <= tmr - 1'b1;

      if (ctl_we) begin
        dly  <= phase ? LD_ODD : LD_EVEN;
        pend <= ctl_data[7:6];
      end else if (dly != '0) begin
        dly <= dly - 1'b1;
      end

      if (apply) begin
        mode <= pend[1];
        inh  <= pend[0];
      end
    end
  end
endmodule

// File: rtl/frame_seq_chk.sv
module frame_seq_chk #(
  parameter int CNT_W  = 16,
  parameter int P4_END = 29830,
  parameter int P5_END = 37282
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stat_rd,
  input logic             qtr,
  input logic             half,
  input logic             irq,
  input logic             stat_frame_irq,
  input logic             mode,
  input logic             inh,
  input logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] SET_LO = CNT_W'(P4_END - 3);
  localparam logic [CNT_W-1:0] SET_HI = CNT_W'(P4_END - 1);
  localparam logic [CNT_W-1:0] TOP    = CNT_W'(P5_END);

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> stat_frame_irq); // R6
  AST_IRQ_AFTER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(stat_frame_irq)); // R6
  AST_QTR_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    qtr |=> !qtr); // R11
  AST_HALF_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    half |=> !half); // R11
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && (mode || inh || cnt < SET_LO || cnt > SET_HI)) |=> !stat_frame_irq); // R7
  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (inh && !stat_frame_irq) |=> !stat_frame_irq); // R5
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= TOP); // R4
endmodule

bind frame_seq frame_seq_chk #(.CNT_W(CNT_W), .P4_END(P4_END), .P5_END(P5_END)) u_chk (
  .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .qtr(qtr), .half(half), .irq(irq),
  .stat_frame_irq(stat_frame_irq), .mode(mode), .inh(inh), .cnt(cnt)
);

// File: tb/sim_frame_seq.sv
module sim_frame_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       phase = 1'b0;
  logic       ctl_we = 1'b0;
  logic [7:0] ctl_data = 8'h00;
  logic       stat_rd = 1'b0;
  logic       qtr, half, irq, stat_frame_irq;

  frame_seq u0 (
    .clk(clk), .rst_n(rst_n), .phase(phase), .ctl_we(ctl_we), .ctl_data(ctl_data),
    .stat_rd(stat_rd), .qtr(qtr), .half(half), .irq(irq), .stat_frame_irq(stat_frame_irq)
  );

  always #2 clk = ~clk;

  typedef struct {
    int         t;
    logic [3:0] v;
    string      tag;
  } ev_t;

  ev_t  exq[$];
  int   tk = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  logic [1:0] prev = 2'b00;

  always @(posedge clk) if (rst_n) tk <= tk + 1;

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  task automatic expect_ev(input int t, input logic [3:0] v, input string tag);
    ev_t e;
    e.t = t; e.v = v; e.tag = tag;
    exq.push_back(e);
  endtask

  // monitor: records each pulse and each change of flag/irq as {qtr,half,flag,irq}
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [3:0] cur;
      cur = {qtr, half, stat_frame_irq, irq};
      if (cur[3] || cur[2] || cur[1:0] != prev) begin
        if (exq.size() == 0) begin
          check(1'b0, "R2 unexpected event", $sformatf("t=%0d v=%b", tk, cur), "none");
        end else begin
          ev_t e;
          e = exq.pop_front();
          check(e.t == tk && e.v == cur, e.tag,
                $sformatf("t=%0d v=%b", tk, cur), $sformatf("t=%0d v=%b", e.t, e.v));
        end
      end
      prev = cur[1:0];
    end
  end

  // drive an input so that it is sampled at edge n
  task automatic drive_at(input int n, input bit rd, input bit we, input logic [7:0] d, input bit ph);
    while (tk != n - 1) @(negedge clk);
    stat_rd = rd; ctl_we = we; ctl_data = d; phase = ph;
    @(negedge clk);
    stat_rd = 1'b0; ctl_we = 1'b0;
  endtask

  initial begin
    // frame 1, 4-step from reset: R2 R3 R5 R6
    expect_ev(7457,  4'b1000, "R2 q1");
    expect_ev(14913, 4'b1100, "R3 q2+half");
    expect_ev(22372, 4'b1000, "R2 q3");
    expect_ev(29828, 4'b0010, "R5 flag set");
    expect_ev(29829, 4'b0110, "R3 half at 29829");
    expect_ev(29830, 4'b1010, "R2 q4");
    expect_ev(29831, 4'b0011, "R6 irq rise");
    expect_ev(30000, 4'b0000, "R7 read clears");
    // frame 2 after wrap at 29830: R3 R8
    expect_ev(37287, 4'b1000, "R3 wrap q1");
    expect_ev(44743, 4'b1100, "R3 wrap q2");
    expect_ev(52202, 4'b1000, "R3 wrap q3");
    expect_ev(59658, 4'b0010, "R5 flag set 2");
    expect_ev(59659, 4'b0110, "R8 read vs set");
    expect_ev(59660, 4'b1010, "R2 q4 2");
    expect_ev(59661, 4'b0011, "R6 irq rise 2");
    expect_ev(59665, 4'b0000, "R7 read clears 2");
    // 5-step applied at 60003 (write 60000, phase 0): R4 R9
    expect_ev(67461, 4'b1000, "R9 R4 q1");
    expect_ev(74916, 4'b1100, "R4 q2+half");
    expect_ev(82375, 4'b1000, "R4 q3");
    expect_ev(97284, 4'b0100, "R4 half 37281");
    expect_ev(97285, 4'b1000, "R4 q 37282");
    // 4-step applied at 100002 (write 100000, phase 1): R9
    expect_ev(107459, 4'b1000, "R9 phase1 q1");
    expect_ev(114915, 4'b1100, "R9 q2");
    expect_ev(122374, 4'b1000, "R9 q3");
    expect_ev(129830, 4'b0010, "R5 flag set 3");
    expect_ev(129831, 4'b0110, "R3 half 3");
    expect_ev(129832, 4'b1010, "R2 q4 3");
    expect_ev(129833, 4'b0011, "R6 irq rise 3");
    // masking byte applied at 130003 (write 130000, phase 0): R10, then no flag
    expect_ev(130003, 4'b0000, "R10 mask clears");
    expect_ev(137460, 4'b1000, "R5 masked q1");
    expect_ev(144916, 4'b1100, "R5 masked q2");
    expect_ev(152375, 4'b1000, "R5 masked q3");
    expect_ev(159832, 4'b0100, "R5 masked half no flag");
    expect_ev(159833, 4'b1000, "R5 masked q4");

    repeat (3) @(negedge clk);
    check({qtr, half, irq, stat_frame_irq} == 4'b0000, "R1 reset outputs",
          $sformatf("%b", {qtr, half, irq, stat_frame_irq}), "0000");
    rst_n = 1'b1;
    @(negedge clk);
    check(!stat_frame_irq && !irq, "R1 after release", $sformatf("%b%b", stat_frame_irq, irq), "00");

    drive_at(30000, 1'b1, 1'b0, 8'h00, 1'b0);
    drive_at(59659, 1'b1, 1'b0, 8'h00, 1'b0);
    check(stat_frame_irq == 1'b1, "R8 flag kept", $sformatf("%b", stat_frame_irq), "1");
    drive_at(59665, 1'b1, 1'b0, 8'h00, 1'b0);
    drive_at(60000, 1'b0, 1'b1, 8'h80, 1'b0);
    drive_at(100000, 1'b0, 1'b1, 8'h00, 1'b1);
    drive_at(130000, 1'b0, 1'b1, 8'h40, 1'b0);
    while (tk < 160000) @(negedge clk);
    check(!irq && !stat_frame_irq, "R10 masked idle", $sformatf("%b%b", irq, stat_frame_irq), "00");
    check(exq.size() == 0, "R2 all events seen", $sformatf("%0d left", exq.size()), "0 left");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(180000 * 4);
    if (!done) begin
      done = 1'b1;
      check(1'b0, "R1 watchdog", "timeout", "finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule